// File: doc/BRIEF.md
# Keyed-Write Watchdog Timer

This block is a bus-attached watchdog built around an 8-bit up-counter. The counter advances once per prescaled tick. Its control register selects the divide ratio, the operating mode and the kind of reset to request. In watchdog mode, a wrap of the counter from all ones to zero emits a single-clock reset request, either power-on or manual. In interval mode, the same wrap raises an interrupt instead.

Every register write must carry a register-specific key byte in a fixed field of the write data. A write without the right key changes nothing. This keeps stray or runaway software stores from reprogramming or silencing the timer. Software normally arms the block with a control write, then writes the refresh register regularly. If the refresh writes stop, the counter wraps.

Top module: `keyed_wdt`

## Requirements
- R1: After reset the count reads 0x00, the control register reads 0x00, and the power-on request, manual request and interrupt outputs are low.
- R2: A write to offset 0x00 loads the count from data[7:0] and restarts the prescaler phase. The write takes effect only when data[15:8] is 0x5A; any other key leaves the count unchanged.
- R3: A write to offset 0x04 updates the control register from data[7:0] only when data[15:8] is 0xA5. The control bits are: bit 7 enable, bit 6 watchdog mode, bit 5 reset type, bit 3 overflow flag, bits [2:0] divide select. Bit 4 always reads 0.
- R4: A write to offset 0x08 clears both the count and the prescaler only when data[31:24] is 0x55. With any other key the write has no effect.
- R5: Reads return the count in [7:0] at offset 0x00 and the control byte in [7:0] at offset 0x04. Every other offset, and every other bit, reads 0.
- R6: While enabled, the count advances by one every 2^(sel+5) clocks, where sel is control bits [2:0]. The first step comes 2^(sel+5) clocks after a count write or a refresh.
- R7: Clearing the enable bit freezes the count and the prescaler. The other control bits keep the values written with it.
- R8: A wrap from 0xFF to 0x00 sets the flag in control bit 3. A keyed control write with bit 3 at 0 clears the flag. Writing bit 3 as 1 never sets it.
- R9: In watchdog mode (bit 6 = 1), a wrap drives a one-clock pulse in the cycle after the wrap edge. The pulse goes to the power-on request when bit 5 = 0 and to the manual request when bit 5 = 1.
- R10: In interval mode (bit 6 = 0), a wrap raises no reset request. The interrupt output stays high for as long as the flag is set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| bus_addr_i | input | 8 | Register byte offset |
| bus_wdata_i | input | 32 | Write data, carrying key and value |
| bus_we_i | input | 1 | Write strobe, one write per cycle |
| bus_rdata_o | output | 32 | Read data for bus_addr_i (combinational) |
| por_req_o | output | 1 | Power-on reset request pulse |
| man_req_o | output | 1 | Manual reset request pulse |
| irq_o | output | 1 | Interval-mode overflow interrupt |

## Verification
The wrap path is exercised with several control patterns: power-on type, manual type, interval mode, and divide selects of 0, 2 and 7. Each one separates the request lines from one another and fixes the exact wrap cycle for that divide ratio. Each register is also written with a wrong key and then with the right key. A mis-keyed refresh that arrives in the middle of a countdown must leave the scheduled wrap in place, whereas a correct refresh must move it. A count read a few clocks before the first post-refresh tick shows whether the prescaler was actually cleared. A long idle period with the enable bit cleared checks that the count stays frozen.

// File: rtl/kwdt_pkg.sv
package kwdt_pkg;

   localparam int unsigned SEL_W = 3;
   localparam int unsigned NSEL  = 1 << SEL_W;

   localparam logic [7:0] OFS_CNT = 8'h00;
   localparam logic [7:0] OFS_CTL = 8'h04;
   localparam logic [7:0] OFS_RFS = 8'h08;

   localparam logic [7:0] KEY_CNT = 8'h5A;
   localparam logic [7:0] KEY_CTL = 8'hA5;
   localparam logic [7:0] KEY_RFS = 8'h55;

   localparam int unsigned B_EN   = 7;
   localparam int unsigned B_WD   = 6;
   localparam int unsigned B_MAN  = 5;
   localparam int unsigned B_FLAG = 3;

   typedef struct packed {
      logic             en;
      logic             wd;
      logic             man;
      logic             flag;
      logic [SEL_W-1:0] sel;
   } ctrl_t;

   function automatic logic [7:0] ctrl_byte(ctrl_t c);
      return {c.en, c.wd, c.man, 1'b0, c.flag, c.sel};
   endfunction

endpackage

// File: rtl/kwdt_prescale.sv
module kwdt_prescale
   import kwdt_pkg::*;
#(
   parameter int unsigned DIV_BASE = 5
) (
   input  logic             clk_i,
   input  logic             rst_ni,
   input  logic             en_i,
   input  logic             clr_i,
   input  logic [SEL_W-1:0] sel_i,
   output logic             tick_o
);

   localparam int unsigned PRE_W = DIV_BASE + NSEL - 1;

   logic [PRE_W-1:0] pre_q;
   logic [NSEL-1:0]  at_end;

   for (genvar g = 0; g < NSEL; g++) begin : g_last
      localparam logic [PRE_W-1:0] LAST =
         PRE_W'((64'd1 << (DIV_BASE + g)) - 64'd1);
      assign at_end[g] = (pre_q >= LAST);
   end

   assign tick_o = en_i && at_end[sel_i];

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
         pre_q <= '0;
      end else if (clr_i) begin
         pre_q <= '0;
      end else if (en_i) begin
         pre_q <= tick_o ? '0 : pre_q + 1'b1;
      end
   end

   // R7
   pre_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (!en_i && !clr_i) |=> $stable(pre_q));

   // R6
   pre_wrap_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      tick_o |=> (pre_q == '0));

endmodule

// File: rtl/kwdt_counter.sv
module kwdt_counter #(
   parameter int unsigned CNT_W = 8
) (
   input  logic             clk_i,
   input  logic             rst_ni,
   input  logic             tick_i,
   input  logic             load_i,
   input  logic [CNT_W-1:0] load_val_i,
   output logic [CNT_W-1:0] cnt_o,
   output logic             ovf_o
);

   logic [CNT_W-1:0] cnt_q;

   assign ovf_o = tick_i && !load_i && (&cnt_q);
   assign cnt_o = cnt_q;

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
         cnt_q <= '0;
      end else if (load_i) begin
         cnt_q <= load_val_i;
      end else if (tick_i) begin
         cnt_q <= cnt_q + 1'b1;
      end
   end

   // R6
   cnt_step_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (tick_i && !load_i) |=> (cnt_q == CNT_W'($past(cnt_q) + 1'b1)));

   // R2
   cnt_load_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      load_i |=> (cnt_q == $past(load_val_i)));

   // R7
   cnt_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (!tick_i && !load_i) |=> $stable(cnt_q));

endmodule

// File: rtl/kwdt_regs.sv
module kwdt_regs
   import kwdt_pkg::*;
#(
   parameter int unsigned ADDR_W = 8,
   parameter int unsigned DATA_W = 32,
   parameter int unsigned CNT_W  = 8
) (
   input  logic              clk_i,
   input  logic              rst_ni,
   input  logic [ADDR_W-1:0] addr_i,
   input  logic [DATA_W-1:0] wdata_i,
   input  logic              we_i,
   input  logic              ovf_i,
   input  logic [CNT_W-1:0]  cnt_i,
   output ctrl_t             ctrl_o,
   output logic              load_o,
   output logic [CNT_W-1:0]  load_val_o,
   output logic [DATA_W-1:0] rdata_o
);

   localparam logic [ADDR_W-1:0] A_CNT = ADDR_W'(OFS_CNT);
   localparam logic [ADDR_W-1:0] A_CTL = ADDR_W'(OFS_CTL);
   localparam logic [ADDR_W-1:0] A_RFS = ADDR_W'(OFS_RFS);

   ctrl_t ctrl_q, ctrl_d;
   logic  hit_cnt, hit_ctl, hit_rfs;
   logic  unused_wdata;

   assign unused_wdata = ^wdata_i[23:16];

   assign hit_cnt = we_i && (addr_i == A_CNT) && (wdata_i[15:8]  == KEY_CNT);
   assign hit_ctl = we_i && (addr_i == A_CTL) && (wdata_i[15:8]  == KEY_CTL);
   assign hit_rfs = we_i && (addr_i == A_RFS) && (wdata_i[31:24] == KEY_RFS);

   assign load_o     = hit_cnt | hit_rfs;
   assign load_val_o = hit_cnt ? wdata_i[CNT_W-1:0] : '0;

   always_comb begin
      ctrl_d = ctrl_q;
      if (hit_ctl) begin
         ctrl_d.en   = wdata_i[B_EN];
         ctrl_d.wd   = wdata_i[B_WD];
         ctrl_d.man  = wdata_i[B_MAN];
         ctrl_d.sel  = wdata_i[SEL_W-1:0];
         ctrl_d.flag = ctrl_q.flag & wdata_i[B_FLAG];
      end
      if (ovf_i) begin
         ctrl_d.flag = 1'b1;
      end
   end

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
         ctrl_q <= '0;
      end else begin
         ctrl_q <= ctrl_d;
      end
   end

   assign ctrl_o = ctrl_q;

   always_comb begin
      rdata_o = '0;
      if (addr_i == A_CNT) begin
         rdata_o[CNT_W-1:0] = cnt_i;
      end else if (addr_i == A_CTL) begin
         rdata_o[7:0] = ctrl_byte(ctrl_q);
      end
   end

   logic [SEL_W+2:0] cfg_bits;
   assign cfg_bits = {ctrl_q.en, ctrl_q.wd, ctrl_q.man, ctrl_q.sel};

   // R3
   ctl_badkey_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (we_i && (addr_i == A_CTL) && (wdata_i[15:8] != KEY_CTL))
      |=> $stable(cfg_bits));

   // R8
   flag_rise_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      $rose(ctrl_q.flag) |-> $past(ovf_i));

endmodule

// File: rtl/kwdt_reqgen.sv
module kwdt_reqgen #(
   parameter bit IRQ_LEVEL = 1'b1
) (
   input  logic clk_i,
   input  logic rst_ni,
   input  logic ovf_i,
   input  logic wd_i,
   input  logic man_i,
   input  logic flag_i,
   output logic por_o,
   output logic man_o,
   output logic irq_o
);

   logic por_q, man_q;

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
         por_q <= 1'b0;
         man_q <= 1'b0;
      end else begin
         por_q <= ovf_i && wd_i && !man_i;
         man_q <= ovf_i && wd_i &&  man_i;
      end
   end

   assign por_o = por_q;
   assign man_o = man_q;

   if (IRQ_LEVEL) begin : g_irq_level
      assign irq_o = flag_i && !wd_i;
   end else begin : g_irq_pulse
      logic irq_q;
      logic unused_flag;
      assign unused_flag = flag_i;
      always_ff @(posedge clk_i or negedge rst_ni) begin
         if (!rst_ni) irq_q <= 1'b0;
         else         irq_q <= ovf_i && !wd_i;
      end
      assign irq_o = irq_q;
   end

   // R9
   por_pulse_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      por_q |=> !por_q);

   // R9
   man_pulse_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      man_q |=> !man_q);

   // R9
   req_excl_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      !(por_q && man_q));

   // R10
   irq_mode_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      irq_o |-> !wd_i);

endmodule

// File: rtl/keyed_wdt.sv
module keyed_wdt
   import kwdt_pkg::*;
#(
   parameter int unsigned ADDR_W    = 8,
   parameter int unsigned DATA_W    = 32,
   parameter int unsigned CNT_W     = 8,
   parameter int unsigned DIV_BASE  = 5,
   parameter bit          IRQ_LEVEL = 1'b1
) (
   input  logic              clk_i,
   input  logic              rst_ni,
   input  logic [ADDR_W-1:0] bus_addr_i,
   input  logic [DATA_W-1:0] bus_wdata_i,
   input  logic              bus_we_i,
   output logic [DATA_W-1:0] bus_rdata_o,
   output logic              por_req_o,
   output logic              man_req_o,
   output logic              irq_o
);

   initial begin
      if (DATA_W != 32) $error("keyed_wdt: DATA_W must be 32");
      if (ADDR_W < 4)   $error("keyed_wdt: ADDR_W too small for offsets");
      if (CNT_W < 2 || CNT_W > 8) $error("keyed_wdt: CNT_W out of range");
      if (DIV_BASE < 1 || DIV_BASE > 24) $error("keyed_wdt: DIV_BASE out of range");
   end

   ctrl_t            ctrl;
   logic             load;
   logic [CNT_W-1:0] load_val;
   logic [CNT_W-1:0] cnt;
   logic             tick;
   logic             ovf;

   kwdt_regs #(
      .ADDR_W (ADDR_W),
      .DATA_W (DATA_W),
      .CNT_W  (CNT_W)
   ) u_regs (
      .clk_i      (clk_i),
      .rst_ni     (rst_ni),
      .addr_i     (bus_addr_i),
      .wdata_i    (bus_wdata_i),
      .we_i       (bus_we_i),
      .ovf_i      (ovf),
      .cnt_i      (cnt),
      .ctrl_o     (ctrl),
      .load_o     (load),
      .load_val_o (load_val),
      .rdata_o    (bus_rdata_o)
   );

   kwdt_prescale #(
      .DIV_BASE (DIV_BASE)
   ) u_pre (
      .clk_i  (clk_i),
      .rst_ni (rst_ni),
      .en_i   (ctrl.en),
      .clr_i  (load),
      .sel_i  (ctrl.sel),
      .tick_o (tick)
   );

   kwdt_counter #(
      .CNT_W (CNT_W)
   ) u_cnt (
      .clk_i      (clk_i),
      .rst_ni     (rst_ni),
      .tick_i     (tick),
      .load_i     (load),
      .load_val_i (load_val),
      .cnt_o      (cnt),
      .ovf_o      (ovf)
   );

   kwdt_reqgen #(
      .IRQ_LEVEL (IRQ_LEVEL)
   ) u_req (
      .clk_i  (clk_i),
      .rst_ni (rst_ni),
      .ovf_i  (ovf),
      .wd_i   (ctrl.wd),
      .man_i  (ctrl.man),
      .flag_i (ctrl.flag),
      .por_o  (por_req_o),
      .man_o  (man_req_o),
      .irq_o  (irq_o)
   );

endmodule

// File: tb/keyed_wdt_tb.sv
module keyed_wdt_tb;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [7:0]  addr = '0;
   logic [31:0] wdata = '0;
   logic        we = 1'b0;
   logic [31:0] rdata;
   logic        por, man, irq;

   int cyc = 0;
   int nvec = 0;
   int nbad = 0;
   bit done = 1'b0;
   logic irq_prev = 1'b0;

   int    q_kind[$];
   int    q_cyc[$];
   string q_req[$];

   always #2 clk = ~clk;
   always @(posedge clk) cyc <= cyc + 1;

   keyed_wdt u_dut (
      .clk_i       (clk),
      .rst_ni      (rst_n),
      .bus_addr_i  (addr),
      .bus_wdata_i (wdata),
      .bus_we_i    (we),
      .bus_rdata_o (rdata),
      .por_req_o   (por),
      .man_req_o   (man),
      .irq_o       (irq)
   );

   task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
      nvec++;
      if (act !== exp) begin
         nbad++;
         $display("FAIL %s: actual %h expected %h", req, act, exp);
      end
   endtask

   task automatic push_evt(int kind, int at, string req);
      q_kind.push_back(kind);
      q_cyc.push_back(at);
      q_req.push_back(req);
   endtask

   task automatic take_evt(int kind);
      nvec++;
      if (q_kind.size() == 0) begin
         nbad++;
         $display("FAIL R9/R10: unexpected event kind actual %0d expected none (cycle %0d)",
                  kind, cyc);
      end else begin
         int    k = q_kind.pop_front();
         int    c = q_cyc.pop_front();
         string r = q_req.pop_front();
         if (k != kind || c != cyc) begin
            nbad++;
            $display("FAIL %s: event actual kind %0d cycle %0d expected kind %0d cycle %0d",
                     r, kind, cyc, k, c);
         end
      end
   endtask

   // monitor: 0 = power-on request, 1 = manual request, 2 = interrupt rise
   always @(negedge clk) begin
      #1;
      if (rst_n && !done) begin
         if (por === 1'b1) take_evt(0);
         if (man === 1'b1) take_evt(1);
         if (irq === 1'b1 && irq_prev !== 1'b1) take_evt(2);
      end
      irq_prev = irq;
   end

   task automatic bus_wr(logic [7:0] a, logic [31:0] d, output int wcyc);
      @(negedge clk);
      addr  = a;
      wdata = d;
      we    = 1'b1;
      wcyc  = cyc + 1;
      @(negedge clk);
      we    = 1'b0;
   endtask

   task automatic bus_rd(logic [7:0] a, output logic [31:0] d);
      @(negedge clk);
      addr = a;
      #1 d = rdata;
   endtask

   task automatic wait_until(int t);
      while (cyc < t) @(negedge clk);
   endtask

   task automatic finish_run();
      done = 1'b1;
      $display("== %0d vectors applied, %0d miscompares ==", nvec, nbad);
      $finish;
   endtask

   initial begin
      #(4 * 150000);
      nvec++;
      nbad++;
      $display("FAIL watchdog: run did not complete");
      finish_run();
   end

   initial begin
      int w, r;
      logic [31:0] d, held;

      repeat (3) @(negedge clk);
      rst_n = 1'b1;

      // R1 reset state
      bus_rd(8'h00, d); chk("R1 count", d, 32'h0);
      bus_rd(8'h04, d); chk("R1 ctrl", d, 32'h0);
      chk("R1 outputs", {29'b0, por, man, irq}, 32'h0);

      // R5 unmapped reads
      bus_rd(8'h08, d); chk("R5 refresh offset reads 0", d, 32'h0);
      bus_rd(8'h0C, d); chk("R5 unmapped reads 0", d, 32'h0);

      // R2 count key
      bus_wr(8'h00, 32'h0000_1237, w);
      bus_rd(8'h00, d); chk("R2 bad key ignored", d, 32'h0);
      bus_wr(8'h00, 32'h0000_5A37, w);
      bus_rd(8'h00, d); chk("R2 keyed load", d, 32'h37);

      // R3 control key, bit 4 and flag
      bus_wr(8'h04, 32'h0000_A4C0, w);
      bus_rd(8'h04, d); chk("R3 bad key ignored", d, 32'h0);
      bus_wr(8'h04, 32'h0000_A57F, w);
      bus_rd(8'h04, d); chk("R3 R8 keyed write, bit4 and flag stay 0", d, 32'h67);
      bus_wr(8'h04, 32'h0000_A500, w);

      // R9 power-on request, R6 select 0
      bus_wr(8'h04, 32'h0000_A5C0, w);
      bus_wr(8'h00, 32'h0000_5AFE, w);
      push_evt(0, w + 64, "R9 power-on pulse");
      wait_until(w + 40);
      bus_rd(8'h00, d); chk("R6 one step after 32 clocks", d, 32'hFF);
      wait_until(w + 70);
      chk("R9 power-on pulse seen", q_kind.size(), 32'd0);
      bus_rd(8'h04, d); chk("R8 flag set by wrap", d, 32'hC8);
      bus_rd(8'h00, d); chk("R8 count wrapped to 0", d, 32'h0);
      bus_wr(8'h04, 32'h0000_A500, w);

      // R4 wrong refresh key leaves the wrap time
      bus_wr(8'h04, 32'h0000_A5C0, w);
      bus_wr(8'h00, 32'h0000_5AFE, w);
      push_evt(0, w + 64, "R4 bad refresh ignored");
      wait_until(w + 40);
      bus_wr(8'h08, 32'h5400_0000, r);
      wait_until(w + 70);
      chk("R4 bad refresh ignored", q_kind.size(), 32'd0);

      // R4 good refresh clears count and prescaler
      bus_wr(8'h00, 32'h0000_5AFE, w);
      wait_until(w + 40);
      bus_wr(8'h08, 32'h5500_0000, r);
      bus_rd(8'h00, d); chk("R4 refresh clears count", d, 32'h0);
      wait_until(r + 27);
      bus_rd(8'h00, d); chk("R4 prescaler cleared", d, 32'h0);
      wait_until(r + 35);
      bus_rd(8'h00, d); chk("R4 R6 first step after refresh", d, 32'h1);

      // R7 disable freezes
      bus_wr(8'h04, 32'h0000_A540, w);
      bus_rd(8'h04, d); chk("R7 other bits kept", d, 32'h40);
      bus_rd(8'h00, held);
      repeat (300) @(negedge clk);
      bus_rd(8'h00, d); chk("R7 count frozen", d, held);

      // R9 manual request
      bus_wr(8'h04, 32'h0000_A5E0, w);
      bus_wr(8'h00, 32'h0000_5AFE, w);
      push_evt(1, w + 64, "R9 manual pulse");
      wait_until(w + 70);
      chk("R9 manual pulse seen", q_kind.size(), 32'd0);
      bus_wr(8'h04, 32'h0000_A500, w);

      // R10 interval mode
      bus_wr(8'h04, 32'h0000_A580, w);
      bus_wr(8'h00, 32'h0000_5AFE, w);
      push_evt(2, w + 64, "R10 interrupt");
      wait_until(w + 70);
      chk("R10 interrupt seen", q_kind.size(), 32'd0);
      chk("R10 interrupt held", {31'b0, irq}, 32'h1);
      bus_rd(8'h04, d); chk("R8 flag in interval mode", d, 32'h88);
      bus_wr(8'h04, 32'h0000_A588, w);
      bus_rd(8'h04, d); chk("R8 write of 1 keeps flag", d, 32'h88);
      bus_wr(8'h04, 32'h0000_A580, w);
      bus_rd(8'h04, d); chk("R8 flag cleared", d, 32'h80);
      chk("R10 interrupt drops with flag", {31'b0, irq}, 32'h0);
      bus_wr(8'h04, 32'h0000_A500, w);

      // R6 select 2 and select 7
      bus_wr(8'h04, 32'h0000_A5C2, w);
      bus_wr(8'h00, 32'h0000_5AFF, w);
      push_evt(0, w + 128, "R6 select 2");
      wait_until(w + 134);
      chk("R6 select 2 wrap", q_kind.size(), 32'd0);
      bus_wr(8'h04, 32'h0000_A500, w);

      bus_wr(8'h04, 32'h0000_A5E7, w);
      bus_wr(8'h00, 32'h0000_5AFF, w);
      push_evt(1, w + 4096, "R6 select 7");
      wait_until(w + 4102);
      chk("R6 select 7 wrap", q_kind.size(), 32'd0);
      bus_wr(8'h04, 32'h0000_A500, w);

      repeat (10) @(negedge clk);
      chk("R9 R10 no pending events", q_kind.size(), 32'd0);
      finish_run();
   end

endmodule